// File: doc/BRIEF.md
# Two-Wire Bus Clock Phase Generator

This block times the low and high halves of the serial clock line for a two-wire bus master. It runs from the system clock and reads one configuration word with three fields: a low-phase divider, a high-phase divider and a power-of-two prescale exponent. Each phase lasts the divider shifted left by the exponent, plus a fixed offset set at build time. When both dividers are equal the bus clock is symmetric, at f_sys / (2 × (div × 2^exp + offset)).

The bus controller sees two signals. One is the requested line level. The other is a one-cycle strobe that fires in the last system clock of each phase. A hold input lets the controller freeze the clock at its present level for as long as it needs. A new configuration word is staged when written and takes effect at the next phase boundary, so the phase in progress is never cut short or stretched by a write.

The core is a two-state machine. `ST_LOW` drives the line low and `ST_HIGH` drives it high. There is one transition, taken when the strobe fires: `ST_LOW` goes to `ST_HIGH` and `ST_HIGH` goes to `ST_LOW`. No other transition exists. Each time the state changes, a down-counter reloads with the length of the phase that is starting.

Top module: `scl_wavegen`

## Requirements
- R1: While reset is active and just after it, the line level is low and the strobe is 0. The first low phase and the first high phase use the lengths given by the reset configuration word.
- R2: Field positions in the configuration word: low divider in bits 7:0, high divider in bits 15:8, exponent in bits 18:16.
- R3: A low phase lasts (low divider × 2^exp + OFFSET) system clocks. A high phase lasts (high divider × 2^exp + OFFSET) system clocks.
- R4: A divider of zero acts as one, so a phase never lasts fewer than 1 + OFFSET clocks.
- R5: An exponent field larger than MAX_EXP is clamped to MAX_EXP when it is written.
- R6: The strobe is high for exactly one cycle, in the last cycle of a phase. The line level changes at the clock edge that follows the strobe, and never at any other edge.
- R7: While hold is 1, the counter is frozen, the strobe stays 0 and the line level does not change. Each held cycle adds one cycle to the current phase.
- R8: A configuration write in the middle of a phase leaves that phase's length unchanged and applies from the next phase. A write in the strobe cycle applies to the phase that starts at that edge.
- R9: Phases alternate strictly between low and high. The state machine has only the transitions `ST_LOW`→`ST_HIGH` and `ST_HIGH`→`ST_LOW`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 2*DIV_W+EXP_W | Configuration word: low divider, high divider, exponent |
| hold | input | 1 | Freeze the clock at its current level |
| scl_toggle | output | 1 | One-cycle strobe in the last cycle of each phase |
| scl_level | output | 1 | Requested serial clock level (1 = high) |

## Verification
The bench sweeps every exponent code, including the codes above the clamp limit, against dividers that include zero, one and values where low and high differ. It measures every phase length arithmetically. If the exponent were not clamped, or a zero divider were not raised to one, those phases would come out at the wrong length, and with a zero divider a phase could even last only the offset. It also writes in the middle of a phase and exactly in the strobe cycle. A design that applied writes at once would shorten or lengthen the running phase, and one that latched them a cycle late would miss the phase that starts at the edge. Hold is applied both briefly and for longer than a whole phase. A wrong counter freeze would either lose the extra cycles or let the line toggle while held.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;

    typedef enum logic [0:0] {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } scl_phase_e;

    // Length of one phase in system clocks; a zero divider counts as one.
    function automatic int unsigned phase_cycles(
        input int unsigned div,
        input int unsigned expo,
        input int unsigned off
    );
        int unsigned d;
        d = (div == 0) ? 1 : div;
        return (d << expo) + off;
    endfunction

endpackage

// File: rtl/scl_cfg_stage.sv
module scl_cfg_stage #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 7,
    parameter logic [2*DIV_W+EXP_W-1:0] RESET_WORD = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2*DIV_W+EXP_W-1:0] wr_word,
    input  logic                     commit,
    output logic [DIV_W-1:0]         nxt_low,
    output logic [DIV_W-1:0]         nxt_high,
    output logic [EXP_W-1:0]         nxt_exp,
    output logic [EXP_W-1:0]         act_exp
);
    localparam int CFG_W = 2*DIV_W + EXP_W;

    function automatic logic [CFG_W-1:0] clamp_word(input logic [CFG_W-1:0] w);
        logic [CFG_W-1:0] r;
        r = w;
        if (w[CFG_W-1 -: EXP_W] > EXP_W'(MAX_EXP))
            r[CFG_W-1 -: EXP_W] = EXP_W'(MAX_EXP);
        return r;
    endfunction

    localparam logic [CFG_W-1:0] RST_CLAMPED = clamp_word(RESET_WORD);

    logic [CFG_W-1:0] pend_q;
    logic [CFG_W-1:0] nxt_word;
    logic [EXP_W-1:0] act_exp_q;

    always_comb begin
        nxt_word = wr_en ? clamp_word(wr_word) : pend_q;
    end

    assign nxt_low  = nxt_word[DIV_W-1:0];
    assign nxt_high = nxt_word[2*DIV_W-1:DIV_W];
    assign nxt_exp  = nxt_word[CFG_W-1 -: EXP_W];
    assign act_exp  = act_exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= RST_CLAMPED;
            act_exp_q <= RST_CLAMPED[CFG_W-1 -: EXP_W];
        end else begin
            if (wr_en)
                pend_q <= clamp_word(wr_word);
            if (commit)
                act_exp_q <= nxt_word[CFG_W-1 -: EXP_W];
        end
    end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int               CNT_W   = 12,
    parameter logic [CNT_W-1:0] RST_LEN = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_LEN;
        end else if (!hold) begin
            if (load)
                cnt_q <= load_val;
            else if (cnt_q > CNT_W'(1))
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
    import scl_wavegen_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 5,
    parameter int OFFSET  = 4,
    parameter logic [2*DIV_W+EXP_W-1:0] RESET_WORD = {3'd2, 8'd10, 8'd10}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2*DIV_W+EXP_W-1:0] cfg_wdata,
    input  logic                     hold,
    output logic                     scl_toggle,
    output logic                     scl_level
);
    localparam int CFG_W   = 2*DIV_W + EXP_W;
    localparam int OFF_W   = $clog2(OFFSET + 2);
    localparam int SHIFT_W = DIV_W + MAX_EXP;
    localparam int CNT_W   = ((SHIFT_W > OFF_W) ? SHIFT_W : OFF_W) + 1;
    localparam int RST_EXP_RAW = int'(RESET_WORD[CFG_W-1 -: EXP_W]);
    localparam int RST_EXP = (RST_EXP_RAW > MAX_EXP) ? MAX_EXP : RST_EXP_RAW;
    localparam logic [CNT_W-1:0] RST_LEN =
        CNT_W'(phase_cycles(int'(RESET_WORD[DIV_W-1:0]), RST_EXP, OFFSET));

    scl_phase_e state_q, state_d;

    logic [DIV_W-1:0] nxt_low, nxt_high, next_div;
    logic [EXP_W-1:0] nxt_exp, act_exp;
    logic [CNT_W-1:0] load_val;
    logic             expire;

    scl_cfg_stage #(
        .DIV_W      (DIV_W),
        .EXP_W      (EXP_W),
        .MAX_EXP    (MAX_EXP),
        .RESET_WORD (RESET_WORD)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_word  (cfg_wdata),
        .commit   (scl_toggle),
        .nxt_low  (nxt_low),
        .nxt_high (nxt_high),
        .nxt_exp  (nxt_exp),
        .act_exp  (act_exp)
    );

    // Length of the phase that begins at the coming boundary
    always_comb begin
        next_div = (state_q == ST_LOW) ? nxt_high : nxt_low;
        load_val = CNT_W'(phase_cycles(int'(next_div), int'(nxt_exp), OFFSET));
    end

    scl_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_LEN (RST_LEN)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .load     (scl_toggle),
        .load_val (load_val),
        .expire   (expire)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (scl_toggle) begin
            unique case (state_q)
                ST_LOW:  state_d = ST_HIGH;
                ST_HIGH: state_d = ST_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LOW;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        scl_toggle = expire && !hold;
        scl_level  = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 5,
    parameter int OFFSET  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic             scl_toggle,
    input logic             scl_level,
    input logic [EXP_W-1:0] act_exp
);
    logic [31:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= '0;
        else if (scl_toggle)
            age_q <= '0;
        else
            age_q <= age_q + 32'd1;
    end

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !scl_level);

    assert_min_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_toggle |-> (age_q >= 32'(OFFSET)));

    assert_exp_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_exp <= EXP_W'(MAX_EXP));

    assert_strobe_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_toggle |=> (scl_level != $past(scl_level)));

    assert_level_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_toggle |=> $stable(scl_level));

    assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !scl_toggle);

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(scl_level));

endmodule

bind scl_wavegen scl_wavegen_chk #(
    .EXP_W   (EXP_W),
    .MAX_EXP (MAX_EXP),
    .OFFSET  (OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .scl_toggle (scl_toggle),
    .scl_level  (scl_level),
    .act_exp    (act_exp)
);

// File: tb/scl_wavegen_bench.sv
module scl_wavegen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int B_MAX_EXP  = 3;
    localparam int B_OFFSET   = 2;
    localparam logic [18:0] B_RESET = {3'd1, 8'd3, 8'd5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [18:0] cfg_wdata = '0;
    logic        hold = 1'b0;
    logic        scl_toggle;
    logic        scl_level;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_wavegen #(
        .DIV_W      (8),
        .EXP_W      (3),
        .MAX_EXP    (B_MAX_EXP),
        .OFFSET     (B_OFFSET),
        .RESET_WORD (B_RESET)
    ) u_scl_wavegen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .hold       (hold),
        .scl_toggle (scl_toggle),
        .scl_level  (scl_level)
    );

    function automatic int exp_len(input int div, input int ex);
        int e, d;
        e = (ex > B_MAX_EXP) ? B_MAX_EXP : ex;
        d = (div == 0) ? 1 : div;
        return (d << e) + B_OFFSET;
    endfunction

    task automatic check(input string tag, input int act, input int expv, input string what);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Counts one phase from its first sampled cycle; optional hold and write inside it.
    task automatic measure_ex(input int hold_k, input int wr_at, input logic [18:0] w,
                              output int n, output logic lvl);
        int c;
        c = 0;
        lvl = scl_level;
        while (scl_level == lvl) begin
            hold = (c < hold_k);
            if (c == wr_at) begin
                cfg_we = 1'b1;
                cfg_wdata = w;
            end else begin
                cfg_we = 1'b0;
            end
            c++;
            @(negedge clk);
        end
        hold = 1'b0;
        cfg_we = 1'b0;
        n = c;
    endtask

    task automatic measure(output int n, output logic lvl);
        measure_ex(0, -1, '0, n, lvl);
    endtask

    task automatic write_cfg(input int lo, input int hi, input int ex);
        cfg_wdata = {3'(ex), 8'(hi), 8'(lo)};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // R6 monitor: the level changes exactly at the edge after a strobe
    logic prev_tog = 1'b0;
    logic prev_scl = 1'b0;
    bit   armed = 1'b0;
    always @(negedge clk) begin
        #1;
        if (rst_n && armed && !done)
            check("R6", int'(scl_level != prev_scl), int'(prev_tog), "level change vs strobe");
        prev_tog = scl_toggle;
        prev_scl = scl_level;
        armed = rst_n;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        int n, e;
        logic lvl, lvl2;
        int divs [5] = '{0, 1, 2, 5, 17};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(scl_level), 0, "level in reset");
        check("R1", int'(scl_toggle), 0, "strobe in reset");
        rst_n = 1'b1;
        measure(n, lvl);
        check("R1", int'(lvl), 0, "first phase level");
        check("R1", n, exp_len(5, 1), "first low phase length");
        measure(n, lvl);
        check("R1", n, exp_len(3, 1), "first high phase length");

        // R2/R3/R4/R5/R9: sweep of exponent codes and dividers
        for (int ex = 0; ex < 8; ex++) begin
            for (int k = 0; k < 5; k++) begin
                int lo, hi;
                string tag;
                lo = divs[k];
                hi = divs[(k + 2) % 5];
                write_cfg(lo, hi, ex);
                measure(n, lvl);
                if (ex > B_MAX_EXP) tag = "R5";
                else if (lo == 0 || hi == 0) tag = "R4";
                else tag = "R3";
                measure(n, lvl);
                e = (lvl == 1'b0) ? exp_len(lo, ex) : exp_len(hi, ex);
                check(tag, n, e, "sweep phase length");
                measure(n, lvl2);
                e = (lvl2 == 1'b0) ? exp_len(lo, ex) : exp_len(hi, ex);
                check(tag, n, e, "sweep next phase length");
                check("R9", int'(lvl2 != lvl), 1, "phase alternation");
            end
        end

        // R2: wide fields with distinct values
        write_cfg(255, 128, 3);
        measure(n, lvl);
        measure(n, lvl);
        check("R2", n, (lvl == 1'b0) ? exp_len(255, 3) : exp_len(128, 3), "wide field length");
        measure(n, lvl);
        check("R2", n, (lvl == 1'b0) ? exp_len(255, 3) : exp_len(128, 3), "wide field other phase");

        // R8: write in the middle of a phase
        write_cfg(3, 4, 2);
        measure(n, lvl);
        measure_ex(0, 3, {3'd0, 8'd2, 8'd1}, n, lvl);
        check("R8", n, (lvl == 1'b0) ? exp_len(3, 2) : exp_len(4, 2), "mid-phase write kept old length");
        measure(n, lvl);
        check("R8", n, (lvl == 1'b0) ? exp_len(1, 0) : exp_len(2, 0), "new config at next phase");

        // R8: write in the strobe cycle applies to the starting phase
        while (!scl_toggle) @(negedge clk);
        write_cfg(6, 1, 1);
        measure(n, lvl);
        check("R8", n, (lvl == 1'b0) ? exp_len(6, 1) : exp_len(1, 1), "write in strobe cycle");

        // R7: hold extends phases
        write_cfg(2, 3, 1);
        measure(n, lvl);
        measure_ex(5, -1, '0, n, lvl);
        e = (lvl == 1'b0) ? exp_len(2, 1) : exp_len(3, 1);
        check("R7", n, e + 5, "hold for 5 cycles");
        measure_ex(1, -1, '0, n, lvl);
        e = (lvl == 1'b0) ? exp_len(2, 1) : exp_len(3, 1);
        check("R7", n, e + 1, "hold for 1 cycle");
        measure_ex(20, -1, '0, n, lvl);
        e = (lvl == 1'b0) ? exp_len(2, 1) : exp_len(3, 1);
        check("R7", n, e + 20, "hold longer than a phase");

        done = 1'b1;
        finish_run();
    end

endmodule